// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in a wide working form (a class code, a sign, a signed unbiased exponent, a 24-bit significand with two extra low bits, and a sticky bit) and packs it into a 32-bit IEEE-754 single-precision word. It rounds the value under one of four rounding modes and raises inexact, overflow and underflow flags. It is meant to sit at the end of an arithmetic pipeline, after the point where results are normalised.

Each accepted input gives one result exactly one clock later. Non-numbers, infinities and zeros bypass rounding. Finite numbers follow one of two paths. On the normal path, a carry out of rounding bumps the exponent. On the subnormal path, the significand is shifted right to the minimum exponent, and any bits lost in the shift are folded into the sticky bit. Results that are too large either saturate to the largest finite value or become infinity; the rounding mode and the sign decide which.

Top module: `sp_result_packer`

## Requirements
- R1: Class code 3 (NaN) packs as the input sign, exponent field 0xFF, fraction bits [21:0] taken from inMant[23:2], and fraction bit 22 forced to 1. All flags are clear.
- R2: Class code 2 (infinity) packs as the sign with exponent 0xFF and a zero fraction. Class code 0 (zero) packs as the sign bit followed by 31 zero bits. All flags are clear for both.
- R3: For class code 1 (number), inMant[25] is the integer bit, inMant[24:2] the fraction, inMant[1] the guard bit and inMant[0] the round bit. The biased exponent is inExp+127. The result is rounded by roundMode: 0 to nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. outInexact is set whenever guard, round or sticky is set after alignment.
- R4: On the normal path, a rounding carry out of the significand adds one to the exponent field and leaves a zero fraction.
- R5: A biased exponent of 0 or less selects the subnormal path. The significand is shifted right by (1 - biased exponent), and any ones shifted out join the sticky bit.
- R6: A subnormal that rounds up to 2^23 is packed as the smallest normal (exponent field 1, fraction 0), with outUnderflow clear.
- R7: Any other subnormal result has exponent field 0. outUnderflow is set only if the result is inexact or underflowTrapEn is high.
- R8: A normal-path result whose final biased exponent is 255 or more overflows. It becomes infinity with outOverflow set in mode 0, in mode 2 for positive values and in mode 3 for negative values.
- R9: An overflow that does not become infinity packs as the signed largest finite value (magnitude 0x7F7FFFFF), with outOverflow clear.
- R10: outValid rises one cycle after inValid, with the word and flags registered alongside it. All three flags are low whenever outValid is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input value present this cycle |
| inClass | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| inSign | input | 1 | Sign of the value |
| inExp | input | 10 | Signed unbiased exponent |
| inMant | input | 26 | Integer bit, 23 fraction bits, guard, round |
| inSticky | input | 1 | OR of all bits below the round bit |
| roundMode | input | 2 | Rounding direction code |
| underflowTrapEn | input | 1 | Underflow trap enable |
| outValid | output | 1 | Packed result present |
| outWord | output | 32 | Packed single-precision word |
| outInexact | output | 1 | Result was rounded |
| outOverflow | output | 1 | Overflowed to infinity |
| outUnderflow | output | 1 | Subnormal underflow |

## Verification
The assertions assume that every class-1 input is normalised, with inMant[25] set, and that inExp is a real exponent within the 10-bit signed range. They also assume that inClass is stable over the cycle in which it is sampled, so that its one-cycle-old value describes the result on the output. The stimulus produces only normalised significands. It draws exponents from a window that covers deep subnormals, the exponent boundaries 0, 1, 254 and 255, and values past overflow. Non-number classes are driven with arbitrary significand bits, to show that only the fields allowed for each class reach the word.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  localparam int EXP_W    = 10;
  localparam int FRAC_W   = 23;
  localparam int EFIELD_W = 8;
  localparam int MANT_W   = FRAC_W + 3;
  localparam int KEEP_W   = FRAC_W + 1;
  localparam int WORD_W   = 1 + EFIELD_W + FRAC_W;
  localparam int BEXP_W   = EXP_W + 1;
  localparam int SH_W     = $clog2(MANT_W + 1);
  localparam int BIAS     = (1 << (EFIELD_W - 1)) - 1;
  localparam int EXP_SAT  = (1 << EFIELD_W) - 1;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fclass_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                     selNan;
    logic                     selInf;
    logic                     selZero;
    logic                     selSub;
    logic [SH_W-1:0]          shiftAmt;
    logic signed [BEXP_W-1:0] biasedExp;
  } pack_ctrl_t;

  typedef struct packed {
    logic inexact;
    logic overflow;
    logic underflow;
  } pack_flags_t;
endpackage

// File: rtl/sp_round_unit.sv
module sp_round_unit
  import sp_pack_pkg::*;
(
  input  logic [KEEP_W-1:0] keepBits,
  input  logic              guardBit,
  input  logic              roundBit,
  input  logic              stickyBit,
  input  logic              signBit,
  input  logic [1:0]        roundMode,
  output logic [KEEP_W:0]   roundedMant,
  output logic              inexact,
  output logic              roundedUp
);
  rmode_e mode;

  always_comb begin
    mode    = rmode_e'(roundMode);
    inexact = guardBit | roundBit | stickyBit;
    unique case (mode)
      RM_NEAREST: roundedUp = guardBit & (roundBit | stickyBit | keepBits[0]);
      RM_ZERO:    roundedUp = 1'b0;
      RM_UP:      roundedUp = inexact & ~signBit;
      RM_DOWN:    roundedUp = inexact & signBit;
      default:    roundedUp = 1'b0;
    endcase
    roundedMant = {1'b0, keepBits} + {{KEEP_W{1'b0}}, roundedUp};
  end

  // R3: an increment only ever follows discarded nonzero bits
  always_comb begin
    a_r3_up_needs_inexact: assert (!roundedUp || inexact);
  end
endmodule

// File: rtl/sp_pack_ctrl.sv
module sp_pack_ctrl
  import sp_pack_pkg::*;
(
  input  logic [1:0]       inClass,
  input  logic [EXP_W-1:0] inExp,
  output pack_ctrl_t       ctl
);
  localparam logic signed [BEXP_W-1:0] BIAS_S  = BEXP_W'(BIAS);
  localparam logic signed [BEXP_W-1:0] SH_CAP  = BEXP_W'(MANT_W);
  localparam logic signed [BEXP_W-1:0] ONE_S   = BEXP_W'(1);

  fclass_e                  cls;
  logic signed [BEXP_W-1:0] biased;
  logic signed [BEXP_W-1:0] shiftFull;
  logic                     isSub;

  always_comb begin
    cls       = fclass_e'(inClass);
    biased    = $signed({inExp[EXP_W-1], inExp}) + BIAS_S;
    shiftFull = ONE_S - biased;
    isSub     = (cls == CLS_NUM) && (biased <= 0);

    ctl.selNan    = (cls == CLS_NAN);
    ctl.selInf    = (cls == CLS_INF);
    ctl.selZero   = (cls == CLS_ZERO);
    ctl.selSub    = isSub;
    ctl.biasedExp = biased;
    if (!isSub)
      ctl.shiftAmt = '0;
    else if (shiftFull > SH_CAP)
      ctl.shiftAmt = SH_W'(MANT_W);
    else
      ctl.shiftAmt = shiftFull[SH_W-1:0];
  end

  // R5: the subnormal shift is at least one place and never beyond the significand
  always_comb begin
    a_r5_shift_range: assert (!isSub || (ctl.shiftAmt >= 1 && ctl.shiftAmt <= SH_W'(MANT_W)));
  end
endmodule

// File: rtl/sp_pack_datapath.sv
module sp_pack_datapath
  import sp_pack_pkg::*;
(
  input  pack_ctrl_t        ctl,
  input  logic              inSign,
  input  logic [MANT_W-1:0] inMant,
  input  logic              inSticky,
  input  logic [1:0]        roundMode,
  input  logic              underflowTrapEn,
  output logic [WORD_W-1:0] packWord,
  output pack_flags_t       flags
);
  localparam logic signed [BEXP_W:0] EXP_SAT_S = (BEXP_W+1)'(EXP_SAT);
  localparam logic [EFIELD_W-1:0]    EXP_ONES  = '1;

  logic [MANT_W-1:0]        shiftedMant, lostMask, alignedMant;
  logic                     stickyAll;
  logic [KEEP_W:0]          roundedMant;
  logic                     rndInexact, rndUp;
  logic                     normCarry, subPromote, ovfRange, toInf;
  logic signed [BEXP_W:0]   bumpedExp;
  rmode_e                   mode;

  // denormalising shifter; ones pushed out join the sticky bit
  assign shiftedMant = inMant >> ctl.shiftAmt;
  assign lostMask    = ~({MANT_W{1'b1}} << ctl.shiftAmt);
  assign alignedMant = ctl.selSub ? shiftedMant : inMant;
  assign stickyAll   = inSticky | (ctl.selSub & (|(inMant & lostMask)));

  sp_round_unit u_round (
    .keepBits   (alignedMant[MANT_W-1:2]),
    .guardBit   (alignedMant[1]),
    .roundBit   (alignedMant[0]),
    .stickyBit  (stickyAll),
    .signBit    (inSign),
    .roundMode  (roundMode),
    .roundedMant(roundedMant),
    .inexact    (rndInexact),
    .roundedUp  (rndUp)
  );

  always_comb begin
    mode       = rmode_e'(roundMode);
    normCarry  = roundedMant[KEEP_W];
    subPromote = roundedMant[KEEP_W-1];
    bumpedExp  = $signed({ctl.biasedExp[BEXP_W-1], ctl.biasedExp})
               + $signed({{BEXP_W{1'b0}}, normCarry});
    ovfRange   = (bumpedExp >= EXP_SAT_S);
    unique case (mode)
      RM_NEAREST: toInf = 1'b1;
      RM_ZERO:    toInf = 1'b0;
      RM_UP:      toInf = ~inSign;
      RM_DOWN:    toInf = inSign;
      default:    toInf = 1'b1;
    endcase
  end

  always_comb begin
    packWord = {inSign, {(WORD_W-1){1'b0}}};
    flags    = '0;
    if (ctl.selNan) begin
      packWord = {inSign, EXP_ONES, 1'b1, inMant[FRAC_W:2]};
    end else if (ctl.selInf) begin
      packWord = {inSign, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (ctl.selZero) begin
      packWord = {inSign, {(WORD_W-1){1'b0}}};
    end else if (ctl.selSub) begin
      flags.inexact = rndInexact;
      if (subPromote) begin
        packWord = {inSign, EFIELD_W'(1), {FRAC_W{1'b0}}};
      end else begin
        packWord        = {inSign, {EFIELD_W{1'b0}}, roundedMant[FRAC_W-1:0]};
        flags.underflow = rndInexact | underflowTrapEn;
      end
    end else begin
      flags.inexact = rndInexact;
      if (ovfRange) begin
        if (toInf) begin
          packWord       = {inSign, EXP_ONES, {FRAC_W{1'b0}}};
          flags.overflow = 1'b1;
        end else begin
          packWord = {inSign, EXP_ONES - EFIELD_W'(1), {FRAC_W{1'b1}}};
        end
      end else begin
        packWord = {inSign, bumpedExp[EFIELD_W-1:0], roundedMant[FRAC_W-1:0]};
      end
    end
  end

  // R4: a normal-path carry always leaves a clean power of two behind
  always_comb begin
    a_r4_carry_clean: assert (!normCarry || (roundedMant[KEEP_W-1:0] == '0));
  end
endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
  import sp_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  input  logic              inSticky,
  input  logic [1:0]        roundMode,
  input  logic              underflowTrapEn,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outInexact,
  output logic              outOverflow,
  output logic              outUnderflow
);
  pack_ctrl_t        ctl;
  logic [WORD_W-1:0] packWord;
  pack_flags_t       flags;

  sp_pack_ctrl u_ctrl (
    .inClass(inClass),
    .inExp  (inExp),
    .ctl    (ctl)
  );

  sp_pack_datapath u_dp (
    .ctl            (ctl),
    .inSign         (inSign),
    .inMant         (inMant),
    .inSticky       (inSticky),
    .roundMode      (roundMode),
    .underflowTrapEn(underflowTrapEn),
    .packWord       (packWord),
    .flags          (flags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outWord      <= '0;
      outInexact   <= 1'b0;
      outOverflow  <= 1'b0;
      outUnderflow <= 1'b0;
    end else begin
      outValid     <= inValid;
      outWord      <= inValid ? packWord : '0;
      outInexact   <= inValid & flags.inexact;
      outOverflow  <= inValid & flags.overflow;
      outUnderflow <= inValid & flags.underflow;
    end
  end

  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(outInexact || outOverflow || outUnderflow));

  a_r8_ovf_is_inf: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOverflow) |-> (outWord[WORD_W-2:0] == {{EFIELD_W{1'b1}}, {FRAC_W{1'b0}}}));

  a_r7_unf_exp_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUnderflow) |-> (outWord[WORD_W-2:FRAC_W] == '0));

  a_r2_inf_pack: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inClass) == 2'd2) |->
      (outWord[WORD_W-2:0] == {{EFIELD_W{1'b1}}, {FRAC_W{1'b0}}} && !outInexact && !outOverflow));

  a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inClass) == 2'd3) |-> (outWord[WORD_W-2:FRAC_W-1] == '1));
endmodule

// File: tb/sp_result_packer_test.sv
module sp_result_packer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inClass = 2'd0;
  logic        inSign = 1'b0;
  logic [9:0]  inExp = '0;
  logic [25:0] inMant = '0;
  logic        inSticky = 1'b0;
  logic [1:0]  roundMode = 2'd0;
  logic        underflowTrapEn = 1'b0;
  logic        outValid;
  logic [31:0] outWord;
  logic        outInexact, outOverflow, outUnderflow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] w;
    logic        ix;
    logic        ov;
    logic        un;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  sp_result_packer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inSign(inSign),
    .inExp(inExp), .inMant(inMant), .inSticky(inSticky), .roundMode(roundMode),
    .underflowTrapEn(underflowTrapEn), .outValid(outValid), .outWord(outWord),
    .outInexact(outInexact), .outOverflow(outOverflow), .outUnderflow(outUnderflow)
  );

  function automatic exp_t model(int cls, bit s, int e, longint m, bit st, int mode, bit trap);
    exp_t r;
    longint q;
    int b, sh;
    bit g, rb, ix, up, sub, lost, toinf;
    r.ix = 0; r.ov = 0; r.un = 0; r.tag = "";
    if (cls == 0) begin r.w = {s, 31'd0}; return r; end
    if (cls == 2) begin r.w = {s, 8'hFF, 23'd0}; return r; end
    if (cls == 3) begin r.w = {s, 8'hFF, 23'(((m >> 2) & 64'h7FFFFF) | 64'h400000)}; return r; end
    b = e + 127;
    sub = (b <= 0);
    if (sub) begin
      sh = 1 - b;
      if (sh >= 26) begin lost = (m != 0); m = 0; end
      else begin lost = ((m & ((64'd1 << sh) - 1)) != 0); m = m >> sh; end
      st = st | lost;
    end
    q = m >> 2; g = m[1]; rb = m[0];
    ix = g | rb | st;
    case (mode)
      0: up = g && (rb || st || q[0]);
      1: up = 0;
      2: up = ix && !s;
      default: up = ix && s;
    endcase
    q = q + longint'(up);
    r.ix = ix;
    if (sub) begin
      if (q == (64'd1 << 23)) r.w = {s, 8'd1, 23'd0};
      else begin r.w = {s, 8'd0, q[22:0]}; r.un = ix | trap; end
    end else begin
      if (q == (64'd1 << 24)) begin b = b + 1; q = 0; end
      if (b >= 255) begin
        toinf = (mode == 0) || (mode == 2 && !s) || (mode == 3 && s);
        if (toinf) begin r.w = {s, 8'hFF, 23'd0}; r.ov = 1; end
        else r.w = {s, 31'h7F7FFFFF};
      end else r.w = {s, b[7:0], q[22:0]};
    end
    return r;
  endfunction

  task automatic drive(int cls, bit s, int e, logic [25:0] m, bit st, int mode, bit trap, string tag);
    exp_t x;
    @(negedge clk);
    inValid = 1; inClass = 2'(cls); inSign = s; inExp = 10'(e); inMant = m;
    inSticky = st; roundMode = 2'(mode); underflowTrapEn = trap;
    x = model(cls, s, e, longint'(m), st, mode, trap);
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic check(bit ok, string tag, logic [34:0] act, logic [34:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: compare each result against the oldest queued expectation
  always @(negedge clk) begin
    if (rstN && outValid) begin
      exp_t x;
      if (sb.size() == 0) begin
        check(0, "R10 unexpected outValid", {outWord, outInexact, outOverflow, outUnderflow}, '0);
      end else begin
        x = sb.pop_front();
        check({outWord, outInexact, outOverflow, outUnderflow} == {x.w, x.ix, x.ov, x.un}, x.tag,
              {outWord, outInexact, outOverflow, outUnderflow}, {x.w, x.ix, x.ov, x.un});
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 0 && outWord == 0 && !outInexact && !outOverflow && !outUnderflow,
          "R10 reset state", {outWord, outInexact, outOverflow, outUnderflow}, '0);
    rstN = 1;

    // R1: NaN keeps fraction bits, quiet bit forced
    drive(3, 1, 0, 26'h0A5A5A4, 0, 0, 0, "R1 nan payload");
    drive(3, 0, 77, 26'h3FFFFFF, 1, 2, 1, "R1 nan all ones");
    // R2: infinity and zero
    drive(2, 0, 5, 26'h2345678, 1, 0, 1, "R2 +inf");
    drive(2, 1, -3, 26'h0, 0, 3, 0, "R2 -inf");
    drive(0, 1, 100, 26'h3FFFFFF, 1, 2, 1, "R2 -zero");
    drive(0, 0, 0, 26'h0, 0, 0, 0, "R2 +zero");
    // R3: exact value and each rounding mode on a tie with odd lsb
    drive(1, 0, 0, 26'h2000000, 0, 0, 0, "R3 exact one");
    for (int md = 0; md < 4; md++) begin
      drive(1, 0, 4, 26'h2000006, 0, md, 0, "R3 tie odd +");
      drive(1, 1, 4, 26'h2000006, 0, md, 0, "R3 tie odd -");
      drive(1, 0, 4, 26'h2000002, 0, md, 0, "R3 tie even +");
      drive(1, 1, -9, 26'h2000001, 1, md, 0, "R3 below half -");
    end
    // R4: carry bumps the exponent
    drive(1, 0, 3, 26'h3FFFFFE, 0, 0, 0, "R4 carry bump");
    drive(1, 1, 3, 26'h3FFFFFF, 0, 3, 0, "R4 carry bump down");
    // R8 / R9: exponent 254 carry and exponent 255 direct
    drive(1, 0, 127, 26'h3FFFFFF, 0, 0, 0, "R8 254 carry to inf");
    drive(1, 0, 127, 26'h3FFFFFF, 0, 1, 0, "R4 254 no carry in rz");
    for (int md = 0; md < 4; md++) begin
      drive(1, 0, 128, 26'h2000000, 0, md, 0, "R8 R9 exp255 +");
      drive(1, 1, 128, 26'h2000000, 0, md, 0, "R8 R9 exp255 -");
      drive(1, 1, 200, 26'h2ABCDEF, 1, md, 0, "R8 R9 far over -");
    end
    // R5: boundary exponents 0 and 1
    drive(1, 0, -126, 26'h2000000, 0, 0, 0, "R5 biased one normal");
    drive(1, 0, -127, 26'h2000000, 0, 0, 0, "R5 biased zero");
    drive(1, 1, -200, 26'h2000000, 0, 2, 0, "R5 deep shift rp neg");
    drive(1, 0, -200, 26'h2000000, 0, 2, 0, "R5 deep shift rp pos");
    // R6: largest subnormal promoted
    drive(1, 0, -127, 26'h3FFFFFF, 0, 0, 0, "R6 promote");
    drive(1, 1, -127, 26'h3FFFFFF, 0, 3, 0, "R6 promote rm");
    drive(1, 0, -127, 26'h3FFFFFF, 0, 1, 0, "R7 no promote rz");
    // R7: exact subnormal with and without trap enable
    drive(1, 0, -130, 26'h2000000, 0, 0, 0, "R7 exact no trap");
    drive(1, 0, -130, 26'h2000000, 0, 0, 1, "R7 exact trap");
    idle();
    idle();
    check(outValid == 0 && !outInexact && !outOverflow && !outUnderflow, "R10 idle after drain",
          {outWord, outInexact, outOverflow, outUnderflow}, '0);

    // mixed random sweep across all paths and modes
    for (int i = 0; i < 3000; i++) begin
      int cls;
      int e;
      logic [25:0] m;
      cls = (($urandom % 16) == 0) ? int'($urandom % 4) : 1;
      e = int'($urandom_range(0, 310)) - 165;
      m = {1'b1, 25'($urandom)};
      drive(cls, 1'($urandom), e, m, 1'($urandom), int'($urandom % 4), 1'($urandom),
            "R3 R5 R8 random");
      if (($urandom % 8) == 0) idle();
    end
    idle();
    idle();
    idle();
    check(sb.size() == 0, "R10 all results returned", 35'(sb.size()), '0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule